// File: doc/BRIEF.md
# Burst Preamble Phase Selector

This block recovers serial data from upstream bursts that share the frequency of the local bit clock but arrive at an unknown phase. Once per bit period it takes an 8-bit vector. Sample 0 is the earliest of eight equally spaced samples inside one bit interval, and sample 7 is the latest. A falling edge on the burst reset input starts a new acquisition. During the alternating preamble that opens every burst, the block finds where the data transitions fall. It then picks the sampling phase that lies half a bit away from them, which is the bit centre.

After it has chosen a phase, the block keeps that phase for the rest of the burst. It routes that phase's samples through a short register pipeline to a single serial output and raises a lock flag when the first valid bit appears there. The output stays low from the burst reset until lock. If the preamble gives no clear answer, the block never locks and the output stays low until the next burst reset. The output is always re-timed to the one free-running bit clock.

Top module: `burst_phase_picker`

## Requirements
- R1: While `rstN` is low, and after it is released until the first burst reset, `lockOut` and `dataOut` are 0.
- R2: A burst reset is `burstRst` sampled 1 at one clock edge and 0 at the next; call that edge E0. After E0, `lockOut` and `dataOut` are 0 and acquisition restarts. A rising edge of `burstRst`, or a level held steady, has no effect. The vector sampled at edge Ej is preamble bit j+1.
- R3: The edge index of a vector is the position i where sample i differs from sample i-1, with sample 7 of the previous vector standing in for i=0. A vote is counted only for a vector with exactly one such position. Bits 1 to 4 of a burst cast no votes.
- R4: The chosen phase is (index with the most votes + 4) mod 8. On a tie, the lower index wins.
- R5: If at least 6 of the 8 votes from bits 5 to 12 agree on one index, `lockOut` rises after edge E17.
- R6: Otherwise the vote of bit 13 is added. If the best index then has at least 6 votes, `lockOut` rises after edge E18.
- R7: If neither check passes, `lockOut` and `dataOut` stay 0 until the next burst reset.
- R8: While locked, `dataOut` after edge Ek equals sample c of the vector sampled at edge Ek-4, where c is the chosen phase. Measured in bit slots, the delay is 4 bits when c is not below the edge index and 5 bits when it is.
- R9: Once high, `lockOut` stays high until the next burst reset. `dataOut` is 0 whenever `lockOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one edge per bit period |
| rstN | input | 1 | Asynchronous active-low reset |
| burstRst | input | 1 | Burst reset; acts on its falling edge |
| phaseSamples | input | 8 | One bit interval sampled at eight phases, bit 0 earliest |
| dataOut | output | 1 | Re-timed serial data, 0 until lock |
| lockOut | output | 1 | High once the phase is acquired and data is valid |

## Verification
The assertions check four rules on every cycle: a falling edge of the burst reset clears lock and data at the following edge; data stays low while lock is low; lock holds until the next burst reset; and lock may rise only 17 or 18 edges after a burst reset. The bench scenarios cover the rest. They sweep all eight arrival phases with random payloads and supply jittered preambles that need the 13th bit or that never settle. They also show that the first four bits are ignored, through a tie that those bits would otherwise flip. Only the bench can show the choice of phase and the 4- or 5-bit delay, because both depend on the input stream.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

  typedef struct packed {
    logic flush;       // burst reset seen: empty output pipeline
    logic clearVotes;  // burst reset seen: zero the vote counters
    logic countEn;     // current vector may cast a vote
    logic latch;       // store the chosen phase
    logic pass;        // chosen phase is valid, feed pipeline
  } bppStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_LOCK,
    ST_FAIL
  } bppState_t;

endpackage

// File: rtl/bpp_vote_bank.sv
module bpp_vote_bank #(
  parameter int PHASES = 8,
  parameter int VOTE_W = 4,
  localparam int IDX_W = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearVotes,
  input  logic              countEn,
  input  logic [PHASES-1:0] curVec,
  input  logic              prevLast,
  output logic [IDX_W-1:0]  bestIdx,
  output logic [VOTE_W-1:0] bestVotes
);

  logic [PHASES-1:0] edgeVec;
  logic              singleEdge;
  logic [VOTE_W-1:0] voteCnt [PHASES];

  // transition position inside the interval, wrapping to the previous vector
  for (genvar g = 0; g < PHASES; g++) begin : gEdge
    if (g == 0) begin : gFirst
      assign edgeVec[g] = curVec[g] ^ prevLast;
    end else begin : gRest
      assign edgeVec[g] = curVec[g] ^ curVec[g-1];
    end
  end

  assign singleEdge = $onehot(edgeVec);

  for (genvar g = 0; g < PHASES; g++) begin : gCnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        voteCnt[g] <= '0;
      end else if (clearVotes) begin
        voteCnt[g] <= '0;
      end else if (countEn && singleEdge && edgeVec[g] && (voteCnt[g] != '1)) begin
        voteCnt[g] <= voteCnt[g] + 1'b1;
      end
    end
  end

  // strict compare keeps the lowest index on a tie
  always_comb begin
    bestVotes = '0;
    bestIdx   = '0;
    for (int i = 0; i < PHASES; i++) begin
      if (voteCnt[i] > bestVotes) begin
        bestVotes = voteCnt[i];
        bestIdx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/bpp_datapath.sv
module bpp_datapath
  import bpp_pkg::*;
#(
  parameter int PHASES     = 8,
  parameter int VOTE_W     = 4,
  parameter int MUX_STAGES = 4,
  localparam int IDX_W = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHASES-1:0] phaseSamples,
  input  bppStrobes_t       strobes,
  output logic [VOTE_W-1:0] topVotes,
  output logic              dataOut,
  output logic              lockOut
);

  localparam int LAST = MUX_STAGES - 1;

  logic [PHASES-1:0]     sampReg;
  logic                  prevLast;
  logic [IDX_W-1:0]      bestIdx;
  logic [IDX_W-1:0]      selPhase;
  logic                  muxBit;
  logic [MUX_STAGES-1:0] dPipe;
  logic [MUX_STAGES-1:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampReg  <= '0;
      prevLast <= 1'b0;
    end else begin
      sampReg  <= phaseSamples;
      prevLast <= sampReg[PHASES-1];
    end
  end

  bpp_vote_bank #(
    .PHASES (PHASES),
    .VOTE_W (VOTE_W)
  ) votes_i (
    .clk        (clk),
    .rstN       (rstN),
    .clearVotes (strobes.clearVotes),
    .countEn    (strobes.countEn),
    .curVec     (sampReg),
    .prevLast   (prevLast),
    .bestIdx    (bestIdx),
    .bestVotes  (topVotes)
  );

  // half an interval away from the edge; wraps because PHASES is a power of two
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPhase <= '0;
    end else if (strobes.latch) begin
      selPhase <= bestIdx + IDX_W'(PHASES / 2);
    end
  end

  assign muxBit = sampReg[selPhase];

  // output pipeline; last stage gates data with its valid bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dPipe <= '0;
      vPipe <= '0;
    end else if (strobes.flush) begin
      dPipe <= '0;
      vPipe <= '0;
    end else begin
      dPipe[0] <= muxBit;
      vPipe[0] <= strobes.pass;
      for (int i = 1; i < MUX_STAGES; i++) begin
        vPipe[i] <= vPipe[i-1];
        if (i == LAST) begin
          dPipe[i] <= dPipe[i-1] & vPipe[i-1];
        end else begin
          dPipe[i] <= dPipe[i-1];
        end
      end
    end
  end

  assign dataOut = dPipe[LAST];
  assign lockOut = vPipe[LAST];

endmodule

// File: rtl/bpp_control.sv
module bpp_control
  import bpp_pkg::*;
#(
  parameter int VOTE_W    = 4,
  parameter int SKIP_BITS = 4,
  parameter int MAIN_BITS = 12,
  parameter int AGREE     = 6,
  localparam int CNT_W = $clog2(MAIN_BITS + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              burstRst,
  input  logic [VOTE_W-1:0] topVotes,
  output bppStrobes_t       strobes
);

  bppState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic             rstQ;
  logic             fall;
  logic             atMain;
  logic             atExtra;
  logic             agreed;

  assign fall    = rstQ & ~burstRst;
  assign atMain  = (bitCnt == CNT_W'(MAIN_BITS));
  assign atExtra = (bitCnt == CNT_W'(MAIN_BITS + 1));
  assign agreed  = (topVotes >= VOTE_W'(AGREE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstQ   <= 1'b0;
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      rstQ <= burstRst;
      if (fall) begin
        state  <= ST_ACQ;
        bitCnt <= '0;
      end else if (state == ST_ACQ) begin
        if (atMain && agreed) begin
          state <= ST_LOCK;
        end else if (atExtra) begin
          state <= agreed ? ST_LOCK : ST_FAIL;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.flush      = fall;
    strobes.clearVotes = fall;
    strobes.countEn    = !fall && (state == ST_ACQ) && (bitCnt >= CNT_W'(SKIP_BITS));
    strobes.latch      = !fall && (state == ST_ACQ) && (atMain || atExtra) && agreed;
    strobes.pass       = (state == ST_LOCK);
  end

endmodule

// File: rtl/burst_phase_picker.sv
module burst_phase_picker #(
  parameter int PHASES     = 8,
  parameter int SKIP_BITS  = 4,
  parameter int MAIN_BITS  = 12,
  parameter int AGREE      = 6,
  parameter int MUX_STAGES = 4,
  localparam int VOTE_W = $clog2(MAIN_BITS + 4)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              burstRst,
  input  logic [PHASES-1:0] phaseSamples,
  output logic              dataOut,
  output logic              lockOut
);

  bpp_pkg::bppStrobes_t strobes;
  logic [VOTE_W-1:0]    topVotes;

  bpp_control #(
    .VOTE_W    (VOTE_W),
    .SKIP_BITS (SKIP_BITS),
    .MAIN_BITS (MAIN_BITS),
    .AGREE     (AGREE)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .burstRst (burstRst),
    .topVotes (topVotes),
    .strobes  (strobes)
  );

  bpp_datapath #(
    .PHASES     (PHASES),
    .VOTE_W     (VOTE_W),
    .MUX_STAGES (MUX_STAGES)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .phaseSamples (phaseSamples),
    .strobes      (strobes),
    .topVotes     (topVotes),
    .dataOut      (dataOut),
    .lockOut      (lockOut)
  );

endmodule

// File: rtl/bpp_checker.sv
module bpp_checker #(
  parameter int MAIN_BITS  = 12,
  parameter int MUX_STAGES = 4
) (
  input logic clk,
  input logic rstN,
  input logic burstRst,
  input logic dataOut,
  input logic lockOut
);

  localparam int LAT = MAIN_BITS + 1 + MUX_STAGES;

  logic       prevRst;
  logic [7:0] sinceFall;
  logic       fallSeen;

  assign fallSeen = prevRst && !burstRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRst   <= 1'b0;
      sinceFall <= '1;
    end else begin
      prevRst <= burstRst;
      if (fallSeen) begin
        sinceFall <= '0;
      end else if (sinceFall != '1) begin
        sinceFall <= sinceFall + 1'b1;
      end
    end
  end

  // R2: burst reset clears lock and data at the next edge
  a_r2_fall_clears: assert property (@(posedge clk) disable iff (!rstN)
    fallSeen |=> (!lockOut && !dataOut));

  // R9: data is blanked while unlocked
  a_r9_blank_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    !lockOut |-> !dataOut);

  // R9: lock holds until a burst reset
  a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut && !fallSeen) |=> lockOut);

  // R5 / R6: lock rises only 17 or 18 edges after a burst reset
  a_r5_lock_timing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOut) |-> (sinceFall == 8'(LAT) || sinceFall == 8'(LAT + 1)));

  // R7: past the last decision point without lock, lock stays low
  a_r7_no_late_lock: assert property (@(posedge clk) disable iff (!rstN)
    (!lockOut && !fallSeen && sinceFall > 8'(LAT + 1)) |=> !lockOut);

endmodule

bind burst_phase_picker bpp_checker #(
  .MAIN_BITS  (MAIN_BITS),
  .MUX_STAGES (MUX_STAGES)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .burstRst (burstRst),
  .dataOut  (dataOut),
  .lockOut  (lockOut)
);

// File: tb/burst_phase_picker_tb_top.sv
module burst_phase_picker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 53;   // 13 preamble bits + 40 payload bits
  localparam int LOCK_MAIN  = 17;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       burstRst = 1'b0;
  logic [7:0] phaseSamples = '0;
  logic       dataOut;
  logic       lockOut;

  int   checks = 0;
  int   errors = 0;
  logic lastBit = 1'b0;
  logic bits [0:NB];
  int   edgeAt [0:NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_phase_picker dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .burstRst     (burstRst),
    .phaseSamples (phaseSamples),
    .dataOut      (dataOut),
    .lockOut      (lockOut)
  );

  function automatic logic [7:0] mkVec(logic prev, logic cur, int e);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = (i < e) ? prev : cur;
    return v;
  endfunction

  task automatic check(string req, logic act, logic exp, int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: got %0b expected %0b", req, k, act, exp);
    end
  endtask

  // mode 0 clean, 1 needs bit 13, 2 never settles, 3 leading-bit tie, 4 rising edge mid-burst
  task automatic runBurst(int p, int mode);
    int   lockEdge;
    int   riseAt;
    int   c;
    int   q;
    int   m;
    logic expLock;
    logic expData;
    string lockTag;
    string dataTag;
    for (int b = 1; b <= NB; b++) begin
      bits[b]   = (b <= 13) ? logic'(b % 2) : logic'($urandom % 2);
      edgeAt[b] = p;
    end
    q = (p + 1) % 8;
    if (mode == 1) begin
      edgeAt[6] = q; edgeAt[9] = q; edgeAt[11] = q;
    end else if (mode == 2) begin
      edgeAt[6] = q; edgeAt[8] = q; edgeAt[10] = q; edgeAt[12] = q;
    end else if (mode == 3) begin
      for (int b = 1; b <= 4; b++) edgeAt[b] = 1;
      edgeAt[7] = 1; edgeAt[10] = 1;
    end
    lockEdge = (mode == 1) ? LOCK_MAIN + 1 : LOCK_MAIN;
    riseAt   = (mode == 4) ? 30 : NB + 1;
    lockTag  = (mode == 1) ? "R6" : (mode == 2) ? "R7" : (mode == 3) ? "R3" :
               (mode == 4) ? "R2" : "R5";
    c = (p + 4) % 8;

    repeat (3) begin
      @(negedge clk);
      burstRst     = 1'b1;
      phaseSamples = mkVec(lastBit, lastBit, 0);
    end
    for (int k = 0; k <= NB; k++) begin
      @(negedge clk);
      if (k > 0) begin
        int e = k - 1;
        expLock = (mode != 2) && (e >= lockEdge);
        m = (c >= p) ? e - 3 : e - 4;
        expData = expLock ? bits[m] : 1'b0;
        dataTag = !expLock ? "R9" : (mode == 0) ? "R4" : "R8";
        if (e == 0) check("R2", lockOut, 1'b0, e);
        else check(lockTag, lockOut, expLock, e);
        check(dataTag, dataOut, expData, e);
      end
      if (k < NB) begin
        burstRst     = (k >= riseAt);
        phaseSamples = mkVec((k == 0) ? lastBit : bits[k], bits[k+1], edgeAt[k+1]);
      end
    end
    lastBit = bits[NB];
  endtask

  initial begin
    void'($urandom(32'h5eed_0b1e));
    repeat (3) @(negedge clk);
    check("R1", lockOut, 1'b0, -1);
    check("R1", dataOut, 1'b0, -1);
    rstN = 1'b1;
    for (int k = 0; k < 6; k++) begin
      phaseSamples = 8'($urandom);
      @(negedge clk);
      check("R1", lockOut, 1'b0, k);
      check("R1", dataOut, 1'b0, k);
    end
    for (int p = 0; p < 8; p++) runBurst(p, 0);
    runBurst(2, 1);
    runBurst(7, 1);
    runBurst(3, 2);
    runBurst(5, 0);
    runBurst(6, 3);
    runBurst(1, 4);
    for (int r = 0; r < 6; r++) runBurst(int'($urandom % 8), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule